// File: doc/BRIEF.md
# Flash Erase Command Interface with Status Register

This block decodes byte-wide commands written by a host on a plain write/read bus. It also keeps the flash status byte and drives a ready/busy output. A single-cycle command selects array reads, selects status reads or clears the sticky error bits. Two-cycle commands erase either one block or every unlocked block. The second cycle of an erase must be the confirm byte. For a block erase, that cycle also carries an address inside the target block.

Before any erase starts, the block checks three things: the sequence itself, the programming-voltage-ok input, and the lock state of the target block. Lock state comes from per-block lock inputs plus a write-protect input that guards the lowest boot blocks. A rejected erase sets its own pair of error bits and leaves the array untouched. An accepted erase goes to an internal sequencer, which holds busy for a fixed number of cycles per block. A behavioural byte array stands in for the flash cells. After reset, word i holds the value i. An erased word reads 0xFF.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, ready is 1, the interface is in array-read mode, word i of the array reads back i, and a status read returns 0x80. Status bits 6, 2 and 0 always read 0.
- R2: A read strobe returns data on rdata one cycle later. Writing 0xFF selects array reads, which return the word at addr. Writing 0x70 selects status reads.
- R3: Writing 0x20 and then 0xD0 with an address in block b drives ready low for BUSY_CYCLES cycles. When ready returns to 1, every word of block b reads 0xFF and all other words are unchanged.
- R4: Writing 0x30 and then 0xD0 erases blocks in ascending index order, taking BUSY_CYCLES cycles per block, with ready low for NUM_BLOCKS*BUSY_CYCLES cycles. Blocks that are locked at their turn are left unchanged.
- R5: If any byte other than 0xD0 follows a setup byte, status bits 4 and 5 are set (status 0xB0) and nothing is erased.
- R6: If vpp_ok is 0 at the confirm cycle, status bits 3 and 5 are set (status 0xA8) and nothing is erased. This check takes precedence over the lock check.
- R7: A block erase aimed at a locked block sets status bits 1 and 5 (status 0xA2) and erases nothing. A block is locked when its lock_bits bit is 1. A block below BOOT_BLOCKS is also locked while wp_n is 0.
- R8: Error bits 5, 4, 3 and 1 stay set until 0x50 is written. That write clears all four of them whatever the level of vpp_ok.
- R9: A setup byte or a confirm cycle switches reads to status data. Reads stay in status mode until 0xFF is written.
- R10: While ready is 0, status bit 7 reads 0 and every write is ignored, including 0x50 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| addr | input | ADDR_W | Word address (block index in upper bits) |
| wdata | input | 8 | Command byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Array word or status byte, registered |
| ready | output | 1 | 1 when idle, 0 while an erase runs |
| vpp_ok | input | 1 | Programming voltage above lockout |
| wp_n | input | 1 | 1 allows boot-block erase |
| lock_bits | input | NUM_BLOCKS | Per-block lock, 1 = locked |

## Verification
Every result of a write or read strobe is due at the first clock edge that samples the strobe. Read data and status appear on rdata one cycle after the strobe. Ready falls at the same edge that takes the confirm byte, and erased words change at the same edge where ready rises again. A behavioural model in the bench steps on each edge and uses the same sampled inputs, so it predicts rdata and ready exactly for each cycle. The bench compares them after every edge, away from the edge, and also makes explicit read-back checks once ready has returned.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] CMD_BLK_SETUP  = 8'h20;
  localparam logic [7:0] CMD_CHIP_SETUP = 8'h30;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;

  // error vector positions (internal)
  localparam int E_ERASE = 3;
  localparam int E_SEQ   = 2;
  localparam int E_VPP   = 1;
  localparam int E_LOCK  = 0;

  typedef enum logic [1:0] {ARM_NONE, ARM_BLOCK, ARM_CHIP} arm_e;
endpackage

// File: rtl/fci_lockmap.sv
module fci_lockmap #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BOOT_BLOCKS = 2
) (
  input  logic [NUM_BLOCKS-1:0] lock_bits,
  input  logic                  wp_n,
  output logic [NUM_BLOCKS-1:0] locked
);
  for (genvar gb = 0; gb < NUM_BLOCKS; gb++) begin : g_blk
    if (gb < BOOT_BLOCKS) begin : g_boot
      assign locked[gb] = lock_bits[gb] | ~wp_n;
    end else begin : g_main
      assign locked[gb] = lock_bits[gb];
    end
  end
endmodule

// File: rtl/fci_decoder.sv
module fci_decoder
  import fci_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wdata,
  input  logic [BLK_W-1:0]      wr_blk,
  input  logic                  vpp_ok,
  input  logic [NUM_BLOCKS-1:0] locked,
  input  logic                  busy,
  output logic                  start_blk,
  output logic                  start_chip,
  output logic [3:0]            err,
  output logic                  show_status
);
  arm_e       arm_q, arm_d;
  logic [3:0] err_q, err_d;
  logic       show_q, show_d;
  logic       take, clr_fire;

  assign take = wr_en & ~busy;

  always_comb begin
    arm_d      = arm_q;
    err_d      = err_q;
    show_d     = show_q;
    start_blk  = 1'b0;
    start_chip = 1'b0;
    clr_fire   = 1'b0;
    if (take) begin
      if (arm_q != ARM_NONE) begin
        arm_d  = ARM_NONE;
        show_d = 1'b1;
        if (wdata != CMD_CONFIRM) begin
          err_d[E_SEQ]   = 1'b1;
          err_d[E_ERASE] = 1'b1;
        end else if (!vpp_ok) begin
          err_d[E_VPP]   = 1'b1;
          err_d[E_ERASE] = 1'b1;
        end else if (arm_q == ARM_BLOCK && locked[wr_blk]) begin
          err_d[E_LOCK]  = 1'b1;
          err_d[E_ERASE] = 1'b1;
        end else if (arm_q == ARM_BLOCK) begin
          start_blk = 1'b1;
        end else begin
          start_chip = 1'b1;
        end
      end else begin
        case (wdata)
          CMD_BLK_SETUP:  begin arm_d = ARM_BLOCK; show_d = 1'b1; end
          CMD_CHIP_SETUP: begin arm_d = ARM_CHIP;  show_d = 1'b1; end
          CMD_CLR_STATUS: begin err_d = '0; clr_fire = 1'b1; end
          CMD_RD_ARRAY:   show_d = 1'b0;
          CMD_RD_STATUS:  show_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= ARM_NONE;
      err_q  <= '0;
      show_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      err_q  <= err_d;
      show_q <= show_d;
    end
  end

  assign err         = err_q;
  assign show_status = show_q;

  // R8: error bits only drop on a clear command
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R5/R6/R7: every cause bit travels with the erase-error bit
  a_r5_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[E_SEQ] | err_q[E_VPP] | err_q[E_LOCK]) |-> err_q[E_ERASE]);
  // R10: no erase is launched while the sequencer runs
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_blk | start_chip));
endmodule

// File: rtl/fci_sequencer.sv
module fci_sequencer #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_blk,
  input  logic                  start_chip,
  input  logic [BLK_W-1:0]      tgt_blk,
  input  logic [NUM_BLOCKS-1:0] locked,
  output logic                  busy,
  output logic                  wipe_en,
  output logic [BLK_W-1:0]      wipe_blk
);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NUM_BLOCKS - 1);

  logic             busy_q, chip_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic             step_end;

  assign step_end = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      chip_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
    end else if (start_blk || start_chip) begin
      busy_q <= 1'b1;
      chip_q <= start_chip;
      cnt_q  <= CNT_TOP;
      blk_q  <= start_chip ? '0 : tgt_blk;
    end else if (busy_q) begin
      if (step_end) begin
        if (chip_q && blk_q != BLK_LAST) begin
          blk_q <= blk_q + 1'b1;
          cnt_q <= CNT_TOP;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign wipe_en  = step_end && !(chip_q && locked[blk_q]);
  assign wipe_blk = blk_q;

  // R4: chip erase walks blocks upward one at a time
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && chip_q && $past(busy_q) && blk_q != $past(blk_q))
      |-> blk_q == $past(blk_q) + 1'b1);
  // R3: the step counter never exceeds its load value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= CNT_TOP);
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 4,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int DEPTH  = NUM_BLOCKS * WORDS_PER_BLOCK,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_en,
  input  logic [BLK_W-1:0]  wipe_blk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_word
);
  logic [7:0] mem [DEPTH];

  for (genvar gw = 0; gw < DEPTH; gw++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[gw] <= 8'(gw);
      else if (wipe_en && wipe_blk == BLK_W'(gw / WORDS_PER_BLOCK))
        mem[gw] <= 8'hFF;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int BOOT_BLOCKS     = 2,
  parameter int BUSY_CYCLES     = 4,
  parameter int ADDR_W          = $clog2(NUM_BLOCKS) + $clog2(WORDS_PER_BLOCK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic                  rd_en,
  output logic [7:0]            rdata,
  output logic                  ready,
  input  logic                  vpp_ok,
  input  logic                  wp_n,
  input  logic [NUM_BLOCKS-1:0] lock_bits
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] locked;
  logic                  busy, start_blk, start_chip, show_status, wipe_en;
  logic [3:0]            err;
  logic [BLK_W-1:0]      wr_blk, wipe_blk;
  logic [7:0]            rd_word, status, rdata_q;

  assign wr_blk = addr[ADDR_W-1 -: BLK_W];

  fci_lockmap #(.NUM_BLOCKS(NUM_BLOCKS), .BOOT_BLOCKS(BOOT_BLOCKS)) u_lock (
    .lock_bits(lock_bits), .wp_n(wp_n), .locked(locked));

  fci_decoder #(.NUM_BLOCKS(NUM_BLOCKS)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .wr_blk(wr_blk),
    .vpp_ok(vpp_ok), .locked(locked), .busy(busy), .start_blk(start_blk),
    .start_chip(start_chip), .err(err), .show_status(show_status));

  fci_sequencer #(.NUM_BLOCKS(NUM_BLOCKS), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_blk(start_blk), .start_chip(start_chip),
    .tgt_blk(wr_blk), .locked(locked), .busy(busy), .wipe_en(wipe_en),
    .wipe_blk(wipe_blk));

  fci_array #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK)) u_arr (
    .clk(clk), .rst_n(rst_n), .wipe_en(wipe_en), .wipe_blk(wipe_blk),
    .rd_addr(addr), .rd_word(rd_word));

  assign status = {~busy, 1'b0, err[E_ERASE], err[E_SEQ], err[E_VPP],
                   1'b0, err[E_LOCK], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= show_status ? status : rd_word;
  end

  assign rdata = rdata_q;
  assign ready = ~busy;

  // R6: an erase only begins when the voltage was good at the confirm
  a_r6_start_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vpp_ok));
  // R10: a status read taken while busy shows bit 7 low
  a_r10_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && show_status && busy) |=> rdata[7] == 1'b0);
  // R3: a busy period starts only from a confirm byte
  a_r3_rise_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wdata == CMD_CONFIRM));
endmodule

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  localparam int NB = 8, WPB = 4, BOOT = 2, BUSY = 8, DEPTH = NB * WPB, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic vpp_ok = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ready;
  logic [NB-1:0] lock_bits = '0;

  always #2 clk = ~clk;

  flash_cmd_if #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(WPB), .BOOT_BLOCKS(BOOT),
                 .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .ready(ready), .vpp_ok(vpp_ok), .wp_n(wp_n),
    .lock_bits(lock_bits));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_mem[DEPTH];
  int m_err, m_busy, m_tgt, m_arm, m_rdata;
  bit m_chip, m_show;

  function automatic bit m_locked(int k);
    return lock_bits[k] || (k < BOOT && !wp_n);
  endfunction

  task automatic m_wipe(int k);
    for (int w = 0; w < WPB; w++) m_mem[k * WPB + w] = 8'hFF;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = i;
      m_err = 0; m_busy = 0; m_arm = 0; m_show = 0; m_rdata = 0; m_chip = 0;
    end else begin
      if (rd_en) m_rdata = m_show ? (((m_busy == 0) ? 8'h80 : 0) | m_err) : m_mem[addr];
      if (m_busy > 0) begin
        m_busy--;
        if (!m_chip && m_busy == 0) m_wipe(m_tgt);
        if (m_chip && m_busy % BUSY == 0) begin
          if (!m_locked(NB - 1 - m_busy / BUSY)) m_wipe(NB - 1 - m_busy / BUSY);
        end
      end else if (wr_en) begin
        if (m_arm != 0) begin
          m_show = 1;
          if (wdata != 8'hD0) m_err |= 8'h30;
          else if (!vpp_ok) m_err |= 8'h28;
          else if (m_arm == 1 && m_locked(addr / WPB)) m_err |= 8'h22;
          else if (m_arm == 1) begin m_busy = BUSY; m_chip = 0; m_tgt = addr / WPB; end
          else begin m_busy = BUSY * NB; m_chip = 1; end
          m_arm = 0;
        end else begin
          case (wdata)
            8'h20: begin m_arm = 1; m_show = 1; end
            8'h30: begin m_arm = 2; m_show = 1; end
            8'h50: m_err = 0;
            8'hFF: m_show = 0;
            8'h70: m_show = 1;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_cmp++;
      if (rdata !== 8'(m_rdata) || ready !== (m_busy == 0)) begin
        n_bad++;
        $display("FAIL %s cycle %0d: rdata=%h ready=%b expected rdata=%h ready=%b",
                 cur_req, cycles, rdata, ready, 8'(m_rdata), (m_busy == 0));
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    // R1 reset state
    chk("R1", ready, 1);
    rd(5, v); chk("R1", v, 5);
    cur_req = "R2"; wr(0, 8'h70); rd(0, v); chk("R1", v, 8'h80);
    wr(0, 8'hFF); rd(30, v); chk("R2", v, 30);
    // R3 block erase of block 3
    cur_req = "R3"; wr(0, 8'h20); wr(13, 8'hD0);
    chk("R3", ready, 0);
    wait_ready();
    rd(0, v); chk("R9", v, 8'h80);
    wr(0, 8'hFF);
    rd(12, v); chk("R3", v, 8'hFF); rd(15, v); chk("R3", v, 8'hFF);
    rd(11, v); chk("R3", v, 11); rd(16, v); chk("R3", v, 16);
    // R5 bad sequence
    cur_req = "R5"; wr(0, 8'h20); wr(8, 8'h55); rd(0, v); chk("R5", v, 8'hB0);
    // R10 busy ignores writes; errors still present
    cur_req = "R10"; wr(0, 8'h20); wr(24, 8'hD0);
    rd(0, v); chk("R10", v, 8'h30);
    wr(0, 8'h50); wr(0, 8'hFF);
    wait_ready();
    rd(0, v); chk("R10", v, 8'hB0);
    // R8 clear with low voltage
    cur_req = "R8"; vpp_ok = 0; wr(0, 8'h50); rd(0, v); chk("R8", v, 8'h80);
    // R6 voltage check, precedence over lock
    cur_req = "R6"; lock_bits = 8'b0010_0000;
    wr(0, 8'h20); wr(20, 8'hD0); rd(0, v); chk("R6", v, 8'hA8);
    vpp_ok = 1; wr(0, 8'h50);
    // R7 locked main block and boot block under write-protect
    cur_req = "R7"; wr(0, 8'h20); wr(20, 8'hD0); rd(0, v); chk("R7", v, 8'hA2);
    wr(0, 8'h50); wp_n = 0;
    wr(0, 8'h20); wr(2, 8'hD0); rd(0, v); chk("R7", v, 8'hA2);
    wr(0, 8'h50); wr(0, 8'hFF);
    rd(20, v); chk("R7", v, 20); rd(2, v); chk("R7", v, 2);
    // R4 chip erase skipping locked blocks 0,1,5
    cur_req = "R4"; wr(0, 8'h30); wr(0, 8'hD0);
    wait_ready();
    rd(0, v); chk("R9", v, 8'h80);
    wr(0, 8'hFF);
    rd(1, v); chk("R4", v, 1); rd(21, v); chk("R4", v, 21);
    rd(9, v); chk("R4", v, 8'hFF); rd(17, v); chk("R4", v, 8'hFF);
    rd(31, v); chk("R4", v, 8'hFF);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule